// File: doc/BRIEF.md
# Integer ALU with Condition-Code Update

This block is the integer execute stage of a processor datapath. It takes two operands, an operation code and the present 4-bit condition code. It computes an arithmetic, logic, shift or multiply result together with a new condition code. Each class of operation rewrites only the flag bits it owns. Every other flag bit is copied from the incoming code, so a flag set by an earlier instruction survives an instruction that does not touch it.

Results pass through one register stage. A start strobe causes the result and the new flags to be captured on the next clock edge, and a one-cycle valid pulse announces them. The result port is twice the data width. The full product of a multiply fills the whole port, and every other operation places its result in the low half. Register-file access, decode, predication and hazard handling belong to neighbouring blocks.

Top module: `int_alu_cc`

## Requirements
- R1: A synchronous active-high reset clears `res_o`, `cc_o` and `valid_o` to zero by the following clock edge.
- R2: When `start_i` is high at a rising edge, that edge captures the result and flags, and `valid_o` is high for the cycle after it. When `start_i` is low at an edge, `valid_o` is low after that edge, and `res_o` and `cc_o` hold their values.
- R3: The condition code is N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Op code 0 (add) produces a+b. It sets C from the carry out of the top bit and V from signed overflow, and it sets Z and N from the result, so all four bits are rewritten. No operation with op code 0 to 9 sets N and Z together.
- R4: Op code 1 (subtract) produces a-b. C is set exactly when a < b taken as unsigned numbers. V is set on signed overflow. Z and N are set from the result.
- R5: Op codes 2, 3 and 4 (AND, OR, XOR) produce the bitwise result. They set Z when the result is zero and N from its bit 31. V and C are copied unchanged from `cc_i`.
- R6: Op codes 5, 6 and 7 are shift left, logical shift right and arithmetic shift right of a. The shift amount is `opb_i[4:0]`, and the higher bits of `opb_i` are ignored.
- R7: A shift sets N and Z from the shifted result. For a non-zero amount s, a left shift sets C to a[32-s] and sets V when any of the s bits shifted out differs from the result's bit 31. For a non-zero amount s, a right shift sets C to a[s-1] and clears V.
- R8: A shift with an amount of zero returns a unchanged and copies V and C from `cc_i`.
- R9: Op code 8 (signed multiply) places the 64-bit product of the sign-extended operands on `res_o`. N is product bit 63, and Z is set only if all 64 bits are zero. V and C are copied from `cc_i`.
- R10: Op code 9 (unsigned multiply) behaves as op code 8, except that the operands are zero-extended.
- R11: For every operation other than the multiplies, `res_o[63:32]` is zero.
- R12: Op codes 10 to 15 are reserved. They produce a zero result and pass `cc_i` to `cc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Capture strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand; its low 5 bits are the shift amount |
| cc_i | input | 4 | Present condition code {N,Z,V,C} |
| res_o | output | 64 | Registered result |
| cc_o | output | 4 | Registered condition code {N,Z,V,C} |
| valid_o | output | 1 | One-cycle pulse marking new results |

## Verification
The hardest case to reach is the left-shift overflow flag. It depends on every bit shifted out compared with the new sign, so a sparse set of operands seldom exercises it fully. The bench sweeps all 64 values of the low six operand bits, which covers every shift amount twice, including the masked upper bit. It does this against several operand patterns, including alternating bits and values with one sign bit. Preserved flags are only observable when the incoming code differs from what the operation would compute. For that reason the incoming condition code rotates through all 16 values across a full cross of boundary operands.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    localparam int CC_W = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_SAR  = 4'd7,
        OP_SMUL = 4'd8,
        OP_UMUL = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         v_o,
    output logic         c_o
);
    logic [W:0] wide;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i};
            c_o  = wide[W];
            v_o  = (a_i[W-1] != b_i[W-1]) && (wide[W-1] != a_i[W-1]);
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i};
            c_o  = wide[W];
            v_o  = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
        end
        res_o = wide[W-1:0];
    end
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
    import int_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    a_i,
    input  logic [SH_W-1:0] amt_i,
    input  shift_kind_e     kind_i,
    output logic [W-1:0]    res_o,
    output logic            v_o,
    output logic            c_o,
    output logic            upd_o
);
    localparam logic [SH_W:0] WIDTH_V = SH_W'(W) == '0 ? (SH_W+1)'(W) : (SH_W+1)'(W);

    logic [SH_W:0]  lead_amt;
    logic [W-1:0]   lost_hi;
    logic [W-1:0]   lost_mask;
    logic [W-1:0]   lost_lo;
    logic signed [W-1:0] sa;

    always_comb begin
        upd_o     = (amt_i != '0);
        lead_amt  = WIDTH_V - {1'b0, amt_i};
        lost_hi   = a_i >> lead_amt;
        lost_mask = {W{1'b1}} >> lead_amt;
        lost_lo   = a_i >> (amt_i - SH_W'(1));
        sa        = $signed(a_i);
        res_o     = a_i;
        v_o       = 1'b0;
        c_o       = 1'b0;
        case (kind_i)
            SH_LEFT: begin
                res_o = a_i << amt_i;
                c_o   = lost_hi[0];
                v_o   = lost_hi != (res_o[W-1] ? lost_mask : '0);
            end
            SH_RLOG: begin
                res_o = a_i >> amt_i;
                c_o   = lost_lo[0];
            end
            default: begin
                res_o = W'(sa >>> amt_i);
                c_o   = lost_lo[0];
            end
        endcase
    end
endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           signed_i,
    output logic [2*W-1:0] prod_o
);
    logic [2*W-1:0] ax;
    logic [2*W-1:0] bx;

    always_comb begin
        ax     = {{W{signed_i & a_i[W-1]}}, a_i};
        bx     = {{W{signed_i & b_i[W-1]}}, b_i};
        prod_o = ax * bx;
    end
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
    import int_alu_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        start_i,
    input  logic [3:0]  op_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [3:0]  cc_i,
    output logic [63:0] res_o,
    output logic [3:0]  cc_o,
    output logic        valid_o
);
    localparam int W    = 32;
    localparam int RW   = 2 * W;
    localparam int SH_W = $clog2(W);

    typedef struct packed {
        logic [RW-1:0]   res;
        logic [CC_W-1:0] cc;
        logic            vld;
    } stage_t;

    stage_t st_d, st_q;

    logic [W-1:0]    as_res;
    logic            as_v, as_c;
    logic [W-1:0]    sh_res;
    logic            sh_v, sh_c, sh_upd;
    logic [RW-1:0]   prod;
    logic [W-1:0]    lg_res;
    shift_kind_e     sh_kind;
    logic [SH_W-1:0] sh_amt;

    assign sh_amt  = opb_i[SH_W-1:0];
    assign sh_kind = (op_i == OP_SHL) ? SH_LEFT : (op_i == OP_SHR) ? SH_RLOG : SH_RARI;

    int_alu_addsub #(.W(W)) addsub_i (
        .a_i(opa_i), .b_i(opb_i), .sub_i(op_i == OP_SUB),
        .res_o(as_res), .v_o(as_v), .c_o(as_c)
    );

    int_alu_shifter #(.W(W), .SH_W(SH_W)) shift_i (
        .a_i(opa_i), .amt_i(sh_amt), .kind_i(sh_kind),
        .res_o(sh_res), .v_o(sh_v), .c_o(sh_c), .upd_o(sh_upd)
    );

    int_alu_mul #(.W(W)) mul_i (
        .a_i(opa_i), .b_i(opb_i), .signed_i(op_i == OP_SMUL), .prod_o(prod)
    );

    always_comb begin
        case (op_i)
            OP_AND:  lg_res = opa_i & opb_i;
            OP_OR:   lg_res = opa_i | opb_i;
            default: lg_res = opa_i ^ opb_i;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = start_i;
        if (start_i) begin
            case (op_i)
                OP_ADD, OP_SUB: begin
                    st_d.res = {{W{1'b0}}, as_res};
                    st_d.cc  = {as_res[W-1], as_res == '0, as_v, as_c};
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.res = {{W{1'b0}}, lg_res};
                    st_d.cc  = {lg_res[W-1], lg_res == '0, cc_i[CC_V], cc_i[CC_C]};
                end
                OP_SHL, OP_SHR, OP_SAR: begin
                    st_d.res = {{W{1'b0}}, sh_res};
                    st_d.cc  = {sh_res[W-1], sh_res == '0,
                                sh_upd ? sh_v : cc_i[CC_V],
                                sh_upd ? sh_c : cc_i[CC_C]};
                end
                OP_SMUL, OP_UMUL: begin
                    st_d.res = prod;
                    st_d.cc  = {prod[RW-1], prod == '0, cc_i[CC_V], cc_i[CC_C]};
                end
                default: begin
                    st_d.res = '0;
                    st_d.cc  = cc_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign cc_o    = st_q.cc;
    assign valid_o = st_q.vld;

    logic is_logic, is_mul, is_shift, is_rshift;
    assign is_logic  = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
    assign is_mul    = (op_i == OP_SMUL) || (op_i == OP_UMUL);
    assign is_rshift = (op_i == OP_SHR) || (op_i == OP_SAR);
    assign is_shift  = is_rshift || (op_i == OP_SHL);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (!valid_o && res_o == '0 && cc_o == '0)); // R1
    AST_VALID_ON_START: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> valid_o); // R2
    AST_VALID_ONE_SHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> !valid_o); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> ($stable(res_o) && $stable(cc_o))); // R2
    AST_NZ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && op_i <= 4'd9) |=> !(cc_o[CC_N] && cc_o[CC_Z])); // R3
    AST_LOGIC_KEEPS_VC: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && is_logic) |=> cc_o[1:0] == $past(cc_i[1:0])); // R5
    AST_RSHIFT_V_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && is_rshift && sh_amt != '0) |=> !cc_o[CC_V]); // R7
    AST_SHIFT0_KEEPS_VC: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && is_shift && sh_amt == '0) |=> (cc_o[1:0] == $past(cc_i[1:0]) && res_o[W-1:0] == $past(opa_i))); // R8
    AST_MUL_KEEPS_VC: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && is_mul) |=> cc_o[1:0] == $past(cc_i[1:0])); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !is_mul) |=> res_o[RW-1:W] == '0); // R11
    AST_RESERVED_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && op_i > 4'd9) |=> (cc_o == $past(cc_i) && res_o == '0)); // R12
endmodule

// File: tb/int_alu_cc_tb.sv
module int_alu_cc_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  op;
    logic [31:0] opa, opb;
    logic [3:0]  cci;
    logic [63:0] res;
    logic [3:0]  cco;
    logic        valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    int_alu_cc dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .cc_i(cci),
        .res_o(res), .cc_o(cco), .valid_o(valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nz(input logic [31:0] r, input logic [1:0] vc);
        return {r[31], r == 32'd0, vc};
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] c, output logic [63:0] er, output logic [3:0] ec);
        logic [32:0] w;
        logic [31:0] r;
        logic        v, cy;
        int          s;
        longint      sp;
        s = int'(b[4:0]);
        er = 64'd0;
        ec = c;
        case (o)
            4'd0: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0];
                v = ($signed(a) + $signed(b)) != (longint'($signed(a)) + longint'($signed(b)));
                v = ((longint'($signed(a)) + longint'($signed(b))) > 64'sd2147483647) ||
                    ((longint'($signed(a)) + longint'($signed(b))) < -64'sd2147483648);
                er = {32'd0, r}; ec = {r[31], r == 0, v, w[32]};
            end
            4'd1: begin
                r = a - b;
                v = ((longint'($signed(a)) - longint'($signed(b))) > 64'sd2147483647) ||
                    ((longint'($signed(a)) - longint'($signed(b))) < -64'sd2147483648);
                er = {32'd0, r}; ec = {r[31], r == 0, v, a < b};
            end
            4'd2: begin r = a & b; er = {32'd0, r}; ec = nz(r, c[1:0]); end
            4'd3: begin r = a | b; er = {32'd0, r}; ec = nz(r, c[1:0]); end
            4'd4: begin r = a ^ b; er = {32'd0, r}; ec = nz(r, c[1:0]); end
            4'd5, 4'd6, 4'd7: begin
                r = a; v = c[1]; cy = c[0];
                for (int i = 0; i < s; i++) begin
                    if (o == 4'd5) begin cy = r[31]; r = {r[30:0], 1'b0}; end
                    else begin cy = r[0]; r = {(o == 4'd7) ? r[31] : 1'b0, r[31:1]}; end
                end
                if (s != 0) begin
                    v = 1'b0;
                    if (o == 4'd5)
                        for (int i = 0; i < s; i++) if (a[31-i] != r[31]) v = 1'b1;
                end
                er = {32'd0, r}; ec = {r[31], r == 0, v, cy};
            end
            4'd8: begin
                sp = longint'($signed(a)) * longint'($signed(b));
                er = sp; ec = {er[63], er == 0, c[1:0]};
            end
            4'd9: begin
                er = {32'd0, a} * {32'd0, b}; ec = {er[63], er == 0, c[1:0]};
            end
            default: begin er = 64'd0; ec = c; end
        endcase
    endtask

    function automatic string tag(input logic [3:0] o, input logic [31:0] b);
        case (o)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3, 4'd4: return "R5";
            4'd5, 4'd6, 4'd7: return (b[4:0] == 0) ? "R8" : "R6 R7";
            4'd8: return "R9";
            4'd9: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
        logic [63:0] er;
        logic [3:0]  ec;
        start = 1'b1; op = o; opa = a; opb = b; cci = c;
        @(negedge clk);
        start = 1'b0;
        model(o, a, b, c, er, ec);
        check(res === er, tag(o, b), res, er);
        check(cco === ec, tag(o, b), {60'd0, cco}, {60'd0, ec});
        check(valid === 1'b1, "R2", {63'd0, valid}, 64'd1);
        if (o != 4'd8 && o != 4'd9)
            check(res[63:32] === 32'd0, "R11", {32'd0, res[63:32]}, 64'd0);
    endtask

    logic [31:0] pats [8];

    initial begin
        logic [63:0] hold_r;
        logic [3:0]  hold_c;
        pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001;
        pats[2] = 32'h7FFF_FFFF; pats[3] = 32'h8000_0000;
        pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;
        pats[6] = 32'hA5A5_A5A5; pats[7] = 32'hFFFF_0001;
        rst = 1'b1; start = 1'b0; op = 4'd0; opa = 0; opb = 0; cci = 0;
        repeat (3) @(negedge clk);
        check(res === 64'd0 && cco === 4'd0 && valid === 1'b0, "R1", {59'd0, valid, cco}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(4'(o), pats[i], pats[j], 4'((i * 3 + j * 5 + o) & 15));

        for (int k = 0; k < 4; k++)
            for (int o = 5; o < 8; o++)
                for (int s = 0; s < 64; s++)
                    run_op(4'(o), pats[k + 3], 32'(s) | (s[0] ? 32'hFFFF_FF00 : 32'h0), 4'(s & 15));

        hold_r = res; hold_c = cco;
        op = 4'd0; opa = 32'h1; opb = 32'h1; cci = 4'hF;
        @(negedge clk);
        check(valid === 1'b0, "R2", {63'd0, valid}, 64'd0);
        check(res === hold_r && cco === hold_c, "R2", res, hold_r);

        run_op(4'd8, 32'hFFFF_FFFF, 32'h2, 4'h3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(res === 64'd0 && cco === 4'd0 && valid === 1'b0, "R1", res, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule